// File: doc/BRIEF.md
# Avionics Receive Word Filter and Buffer

This block sits behind a serial receiver for 32-bit avionics data words. When the receiver signals that a complete word has been assembled, the block checks the word's parity. It then decides whether the word is wanted, using an optional label lookup and an optional compare of bits 9 and 10. Wanted words are queued in a 32-entry buffer. Before a word is stored, its bit 32 is replaced by a parity-error flag, so the host sees a clean flag instead of the raw parity bit.

The host collects queued words sixteen bits at a time. A select input chooses the low or the high half of the oldest word. Reading the high half retires the word. Three status outputs report that data is waiting, that the buffer is at least half full, and that it is full.

A small table of sixteen 8-bit allowed labels is loaded through a simple write port. Bit numbering below counts from 1. Word bit n is `rx_word[n-1]`, so the label is `rx_word[7:0]`, bit 9 is `rx_word[8]`, bit 10 is `rx_word[9]` and bit 32 is `rx_word[31]`.

Top module: `awf_rx_filter`

## Requirements
- R1: After reset, `data_ready`, `half_full` and `full` are low, and all sixteen label table entries hold 8'h00.
- R2: A stored word keeps bits 1 to 31 as received. Its bit 32 is 0 if the received 32-bit word had an odd number of ones, and 1 otherwise; a word with even parity is still stored.
- R3: With `label_en` high, a word is stored only if `rx_word[7:0]` equals at least one label table entry.
- R4: With `sd_en` high, a word is stored only if `rx_word[8]` equals `sd_ref[0]` and `rx_word[9]` equals `sd_ref[1]`.
- R5: With both `label_en` and `sd_en` high, a word is stored only if it passes both checks. With both low, every word presented with `eos` is stored while space remains.
- R6: A word is considered only in a cycle where `eos` is high. `rx_word` has no effect in any other cycle.
- R7: Stored words are read back in arrival order, and the buffer holds up to 32 words.
- R8: `data_ready` is high while at least 1 word is held, `half_full` while at least 16 are held, and `full` while 32 are held.
- R9: A word that arrives while the buffer is full is dropped, and `full` stays high.
- R10: `rd_data` shows bits [15:0] of the oldest word when `rd_sel` is 0 and bits [31:16] when `rd_sel` is 1. A cycle with `rd_en` high and `rd_sel` 1 removes that word. A cycle with `rd_en` high and `rd_sel` 0 removes nothing, and `rd_en` on an empty buffer has no effect.
- R11: A cycle with `lbl_we` high writes `lbl_data` into label table entry `lbl_addr`. The new entry applies to words presented with `eos` from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| eos | input | 1 | Strobe: `rx_word` holds a complete word |
| rx_word | input | 32 | Received word |
| label_en | input | 1 | Enable the label table filter |
| sd_en | input | 1 | Enable the bit 9/10 filter |
| sd_ref | input | 2 | Required values: [0] for bit 9, [1] for bit 10 |
| lbl_we | input | 1 | Label table write strobe |
| lbl_addr | input | 4 | Label table entry index |
| lbl_data | input | 8 | Label value to write |
| rd_en | input | 1 | Host read strobe |
| rd_sel | input | 1 | Half select: 0 low half, 1 high half (retires the word) |
| rd_data | output | 16 | Selected half of the oldest stored word |
| data_ready | output | 1 | At least one word held |
| half_full | output | 1 | At least 16 words held |
| full | output | 1 | 32 words held |

## Verification
The bench builds the block with its default parameters: a 32-word buffer and a 16-entry label table. With these sizes, the full and half-full thresholds and the drop-on-full path can be reached by a few dozen directed pushes. Every label table entry can also be written and matched. Random words are driven under all four filter settings, with labels drawn often from the table so that hits and misses both occur. Directed cases cover label 0 against the zeroed table, a fill past full, a complete drain in order, and reads of the low half or of an empty buffer that must not remove anything.

// File: rtl/awf_pkg.sv
package awf_pkg;

    localparam int WORD_W  = 32;
    localparam int HALF_W  = 16;
    localparam int LABEL_W = 8;

    // Field view of a received word (bit 1 of the word is bit 0 here)
    typedef struct packed {
        logic         flag;   // word bit 32
        logic [20:0]  body;   // word bits 11..31
        logic [1:0]   sdi;    // word bits 9..10
        logic [7:0]   label;  // word bits 1..8
    } rx_word_t;

    typedef struct packed {
        logic       label_en;
        logic       sd_en;
        logic [1:0] sd_ref;
    } filt_cfg_t;

    // 1 when the word carries an odd number of ones
    function automatic logic parity_good(rx_word_t w);
        return ^w;
    endfunction

    // Replace bit 32 with the parity error flag
    function automatic rx_word_t stamp_flag(rx_word_t w);
        rx_word_t o;
        o      = w;
        o.flag = ~parity_good(w);
        return o;
    endfunction

endpackage

// File: rtl/awf_label_mem.sv
module awf_label_mem #(
    parameter int ENTRIES = 16,
    parameter int LBL_W   = 8,
    localparam int AW     = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [LBL_W-1:0] wdata,
    input  logic [LBL_W-1:0] probe,
    output logic             hit
);
    logic [LBL_W-1:0] tbl [ENTRIES];
    logic [ENTRIES-1:0] eq;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) tbl[i] <= '0;
        end else if (we) begin
            tbl[waddr] <= wdata;
        end
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign eq[g] = (tbl[g] == probe);
    end

    assign hit = |eq;
endmodule

// File: rtl/awf_word_gate.sv
module awf_word_gate
    import awf_pkg::*;
(
    input  logic      eos,
    input  rx_word_t  word_in,
    input  filt_cfg_t cfg,
    input  logic      label_hit,
    output logic      load,
    output rx_word_t  word_out
);
    logic lbl_ok;
    logic sd_ok;

    always_comb begin
        lbl_ok   = !cfg.label_en || label_hit;
        sd_ok    = !cfg.sd_en || (word_in.sdi == cfg.sd_ref);
        load     = eos && lbl_ok && sd_ok;
        word_out = stamp_flag(word_in);
    end
endmodule

// File: rtl/awf_rx_fifo.sv
module awf_rx_fifo #(
    parameter int DEPTH = 32,
    parameter int WIDTH = 32,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic [CW-1:0]    level,
    output logic             not_empty,
    output logic             half,
    output logic             is_full
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wp;
    logic [AW-1:0]    rp;

    always_ff @(posedge clk) begin
        if (push) mem[wp] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            if (push) wp <= wp + 1'b1;
            if (pop)  rp <= rp + 1'b1;
            case ({push, pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    assign head      = mem[rp];
    assign not_empty = (level != '0);
    assign half      = (level >= CW'(DEPTH / 2));
    assign is_full   = (level == CW'(DEPTH));
endmodule

// File: rtl/awf_rx_filter.sv
module awf_rx_filter
    import awf_pkg::*;
#(
    parameter int FIFO_DEPTH  = 32,
    parameter int LBL_ENTRIES = 16
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           eos,
    input  logic [31:0]                    rx_word,
    input  logic                           label_en,
    input  logic                           sd_en,
    input  logic [1:0]                     sd_ref,
    input  logic                           lbl_we,
    input  logic [$clog2(LBL_ENTRIES)-1:0] lbl_addr,
    input  logic [7:0]                     lbl_data,
    input  logic                           rd_en,
    input  logic                           rd_sel,
    output logic [15:0]                    rd_data,
    output logic                           data_ready,
    output logic                           half_full,
    output logic                           full
);
    localparam int CW = $clog2(FIFO_DEPTH) + 1;

    rx_word_t        w_in;
    rx_word_t        w_store;
    filt_cfg_t       cfg;
    logic            lbl_hit;
    logic            load;
    logic            push;
    logic            pop;
    logic [WORD_W-1:0] head;
    logic [CW-1:0]   fifo_level;

    assign w_in = rx_word_t'(rx_word);
    assign cfg  = '{label_en: label_en, sd_en: sd_en, sd_ref: sd_ref};

    awf_label_mem #(.ENTRIES(LBL_ENTRIES), .LBL_W(LABEL_W)) u_lbl (
        .clk   (clk),
        .rst   (rst),
        .we    (lbl_we),
        .waddr (lbl_addr),
        .wdata (lbl_data),
        .probe (w_in.label),
        .hit   (lbl_hit)
    );

    awf_word_gate u_gate (
        .eos       (eos),
        .word_in   (w_in),
        .cfg       (cfg),
        .label_hit (lbl_hit),
        .load      (load),
        .word_out  (w_store)
    );

    assign push = load && !full;
    assign pop  = rd_en && rd_sel && data_ready;

    awf_rx_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(WORD_W)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .wdata     (w_store),
        .pop       (pop),
        .head      (head),
        .level     (fifo_level),
        .not_empty (data_ready),
        .half      (half_full),
        .is_full   (full)
    );

    assign rd_data = rd_sel ? head[WORD_W-1:HALF_W] : head[HALF_W-1:0];
endmodule

// File: rtl/awf_rx_filter_chk.sv
module awf_rx_filter_chk #(
    parameter int DEPTH = 32,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst,
    input logic          eos,
    input logic [31:0]   rx_word,
    input logic          label_en,
    input logic          sd_en,
    input logic [1:0]    sd_ref,
    input logic          rd_en,
    input logic          rd_sel,
    input logic          data_ready,
    input logic          half_full,
    input logic          full,
    input logic [CW-1:0] level
);
    logic rd_pop;
    assign rd_pop = rd_en && rd_sel;

    AST_NO_LOAD_WITHOUT_EOS: assert property (@(posedge clk) disable iff (rst)
        !eos && !rd_pop |=> level == $past(level)); // R6

    AST_LOW_HALF_KEEPS: assert property (@(posedge clk) disable iff (rst)
        rd_en && !rd_sel && !eos |=> level == $past(level)); // R10

    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        full && !rd_pop |=> full); // R9

    AST_FLAG_NESTING: assert property (@(posedge clk) disable iff (rst)
        full |-> half_full && data_ready); // R8

    AST_OPEN_LOADS: assert property (@(posedge clk) disable iff (rst)
        eos && !label_en && !sd_en && !full && !rd_pop
        |=> level == $past(level) + 1'b1); // R5

    AST_SD_REJECT: assert property (@(posedge clk) disable iff (rst)
        eos && sd_en && (rx_word[9:8] != sd_ref) && !rd_pop
        |=> level == $past(level)); // R4
endmodule

bind awf_rx_filter awf_rx_filter_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .eos        (eos),
    .rx_word    (rx_word),
    .label_en   (label_en),
    .sd_en      (sd_en),
    .sd_ref     (sd_ref),
    .rd_en      (rd_en),
    .rd_sel     (rd_sel),
    .data_ready (data_ready),
    .half_full  (half_full),
    .full       (full),
    .level      (fifo_level)
);

// File: tb/awf_rx_filter_tb.sv
module awf_rx_filter_tb;
    logic        clk = 0;
    logic        rst = 1;
    logic        eos = 0;
    logic [31:0] rx_word = '0;
    logic        label_en = 0, sd_en = 0;
    logic [1:0]  sd_ref = '0;
    logic        lbl_we = 0;
    logic [3:0]  lbl_addr = '0;
    logic [7:0]  lbl_data = '0;
    logic        rd_en = 0, rd_sel = 0;
    logic [15:0] rd_data;
    logic        data_ready, half_full, full;

    int total = 0, bad = 0;
    logic [31:0] q[$];
    logic [7:0]  lbl_m [16];
    bit          done = 0;

    always #2 clk = ~clk;

    awf_rx_filter u_dut (
        .clk(clk), .rst(rst), .eos(eos), .rx_word(rx_word),
        .label_en(label_en), .sd_en(sd_en), .sd_ref(sd_ref),
        .lbl_we(lbl_we), .lbl_addr(lbl_addr), .lbl_data(lbl_data),
        .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data),
        .data_ready(data_ready), .half_full(half_full), .full(full)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic bit exp_load(logic [31:0] w, bit le, bit se, logic [1:0] sr);
        bit hit = 0;
        for (int i = 0; i < 16; i++) if (lbl_m[i] == w[7:0]) hit = 1;
        return (!le || hit) && (!se || w[9:8] == sr);
    endfunction

    function automatic logic [31:0] exp_store(logic [31:0] w);
        return {~(^w), w[30:0]};
    endfunction

    task automatic check_flags(input string tag);
        int n = q.size();
        chk(data_ready == (n >= 1), {tag, " R8 data_ready"}, 32'(data_ready), 32'(n >= 1));
        chk(half_full == (n >= 16), {tag, " R8 half_full"}, 32'(half_full), 32'(n >= 16));
        chk(full == (n == 32), {tag, " R8 full"}, 32'(full), 32'(n == 32));
    endtask

    task automatic send(input logic [31:0] w);
        eos = 1; rx_word = w;
        if (exp_load(w, label_en, sd_en, sd_ref) && q.size() < 32) q.push_back(exp_store(w));
        @(negedge clk);
        eos = 0; rx_word = $urandom;
    endtask

    task automatic pop_check(input string tag);
        logic [31:0] e;
        if (q.size() == 0) return;
        e = q[0];
        rd_sel = 0; #1;
        chk(rd_data == e[15:0], {tag, " R10 low half R2 R7"}, 32'(rd_data), 32'(e[15:0]));
        rd_en = 1; @(negedge clk); rd_en = 0;
        check_flags({tag, " R10 low read keeps"});
        rd_sel = 1; #1;
        chk(rd_data == e[31:16], {tag, " R10 high half R2 R7"}, 32'(rd_data), 32'(e[31:16]));
        rd_en = 1; void'(q.pop_front()); @(negedge clk); rd_en = 0; rd_sel = 0;
        check_flags({tag, " R10 pop"});
    endtask

    task automatic write_lbl(input int a, input logic [7:0] d);
        lbl_we = 1; lbl_addr = 4'(a); lbl_data = d;
        @(negedge clk);
        lbl_we = 0; lbl_m[a] = d;
    endtask

    initial begin
        #(4 * 150000);
        $display("FAIL watchdog R0 act=%h exp=%h", 32'd0, 32'd1);
        bad++; total++;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_A429));
        for (int i = 0; i < 16; i++) lbl_m[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 0;
        check_flags("R1 reset");

        // R1: table zeroed -> label 0 passes, label 5A fails
        label_en = 1;
        send(32'h0000_0100);
        check_flags("R1 R3 label zero hit");
        send(32'h0000_015A);
        check_flags("R1 R3 label miss");
        pop_check("R1");
        label_en = 0;

        // R11: load table, new entry applies next cycle
        for (int i = 0; i < 16; i++) write_lbl(i, 8'(8'h10 + i * 7));
        label_en = 1;
        send(32'hABCD_0010);
        check_flags("R11 R3 written label hits");
        send(32'hABCD_0000);
        check_flags("R11 R3 old zero label gone");
        pop_check("R11");
        label_en = 0;

        // R6: rx_word without eos
        rx_word = 32'h1234_5678; @(negedge clk);
        rx_word = 32'h8765_4321; @(negedge clk);
        check_flags("R6 no eos");

        // R2: even parity word still stored with flag 1
        send(32'h0000_0003);
        send(32'h0000_0001);
        send(32'h8000_0000);
        pop_check("R2 even");
        pop_check("R2 odd");
        pop_check("R2 top bit");

        // Random mix (R3 R4 R5)
        for (int it = 0; it < 400; it++) begin
            logic [31:0] w = $urandom;
            label_en = $urandom_range(0, 1);
            sd_en    = $urandom_range(0, 1);
            sd_ref   = 2'($urandom);
            if ($urandom_range(0, 1)) w[7:0] = lbl_m[$urandom_range(0, 15)];
            send(w);
            check_flags("R3 R4 R5 random");
            if (q.size() > 20 || $urandom_range(0, 3) == 0) pop_check("R5 random");
        end
        label_en = 0; sd_en = 0;
        while (q.size() > 0) pop_check("R7 drain");

        // R4 directed: each mismatch rejected
        sd_en = 1; sd_ref = 2'b10;
        send(32'h0000_0200);
        send(32'h0000_0100);
        send(32'h0000_0000);
        send(32'h0000_0300);
        check_flags("R4 only match loaded");
        pop_check("R4");
        sd_en = 0;

        // R5 both: label ok, sdi bad -> drop; both ok -> load
        label_en = 1; sd_en = 1; sd_ref = 2'b01;
        send({22'h0, 2'b10, lbl_m[3]});
        send({22'h0, 2'b01, 8'hFF});
        send({22'h5, 2'b01, lbl_m[9]});
        check_flags("R5 both");
        pop_check("R5 both");
        label_en = 0; sd_en = 0;

        // R7 R8 R9 fill past full
        for (int i = 0; i < 34; i++) begin
            send(32'hC000_0000 + 32'(i));
            check_flags("R8 R9 fill");
        end
        chk(full == 1, "R9 full stays", 32'(full), 32'd1);
        // read on full with low half, no pop; rd_en on empty later
        for (int i = 0; i < 32; i++) pop_check("R7 ordered drain");
        rd_en = 1; rd_sel = 1; @(negedge clk); rd_en = 0; rd_sel = 0;
        check_flags("R10 empty read");
        send(32'h0000_0007);
        pop_check("R10 after empty read");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule